// File: doc/BRIEF.md
# Stereo Audio Serial Master Engine

This block drives a two-channel audio serial link as the only bus master. It derives the bit clock and the word-select from a master clock that runs at 256 times the sample rate. Each frame has 64 bit periods: the left channel fills the first 32 bit slots and the right channel fills the last 32. A transmit line carries samples out and a separate receive line brings samples in. Three framings are offered: standard (MSB one slot after the word-select edge), MSB-aligned and LSB-aligned.

The sample width can be 8, 16, 18, 20 or 24 bits. The pin polarity of the bit clock and of the word-select can each be inverted. An internal loop can feed the transmit stream into the receiver. Samples enter and leave as stereo pairs through a one-entry push interface and a one-entry pop interface. Four sticky flags record when either interface has been used wrongly. The serial side runs only while the enable pair reads clock-on and not-disabled. A start-up writes both bits set first and then clock-on alone.

Top module: `i2s_master_engine`

## Requirements
- R1: While running, `bclk` has a period of 4 `mclk` cycles and every frame lasts 64 bit periods. The unbiased word-select is low for the left half (slots 0 to 31) and high for the right half. It changes only as the unbiased bit clock falls.
- R2: `cfg_fmt` selects the framing. With sample width W and slot position p inside a half (0 to 31): value 0 puts sample bit W-p in slots 1..W; value 1 puts bit W-1-p in slots 0..W-1; value 2 puts bit 31-p in slots 32-W..31. All other slots transmit 0.
- R3: `cfg_width` is a binary bit count. Only 8, 16, 18, 20 and 24 are legal, and samples sit in the low W bits of the 24-bit sample ports. An illegal width, or `cfg_fmt` = 3, keeps the engine idle.
- R4: `cfg_bclk_inv` inverts the `bclk` pin and `cfg_ws_inv` inverts the `ws` pin. Neither changes the data placement.
- R5: With `cfg_loop` = 1 the receiver takes the transmit stream and ignores `sd_in`. A pair that is pushed comes back unchanged, masked to W bits.
- R6: `tx_push` stores a pair when `tx_full` is 0. At each frame start with `cfg_tx_en` = 1, the stored pair is moved into the frame and `tx_full` clears. With `cfg_tx_en` = 0, the frame carries zeros and the stored pair is kept.
- R7: The receiver samples `sd_in` while the unbiased bit clock rises. At the end of every complete frame with `cfg_rx_en` = 1, it presents the pair on `rx_left`/`rx_right` with `rx_avail` = 1; bits above W read 0. `rx_pop` frees the pair. With `cfg_rx_en` = 0, nothing is delivered.
- R8: `flow_err` is sticky: bit 0 transmit underflow (frame start with transmit on and nothing stored), bit 1 transmit overflow (push while full, pair dropped), bit 2 receive underflow (pop while empty), bit 3 receive overflow (a pair arrives while the previous one is unread; the old pair is kept). A 1 in `flow_clr` clears the matching bit, and a new event in the same cycle wins.
- R9: The engine runs only when `ctl_clk_on` = 1 and `ctl_off` = 0. When idle, `bclk` rests at 1, `ws` at 1 (both before inversion) and `sd_out` at 0. The first frame starts on the first running `mclk` edge.
- R10: `sd_out` changes only while the unbiased bit clock is low.
- R11: After reset, `tx_full`, `rx_avail` and `flow_err` are 0, `sd_out` is 0, and the unbiased `bclk` and `ws` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock, 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fmt | input | 2 | Framing select (0 standard, 1 MSB-aligned, 2 LSB-aligned) |
| cfg_width | input | 5 | Sample width in bits |
| cfg_bclk_inv | input | 1 | Invert bit-clock pin |
| cfg_ws_inv | input | 1 | Invert word-select pin |
| cfg_loop | input | 1 | Internal loop from transmit to receive |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| ctl_off | input | 1 | Disable bit of the enable pair |
| ctl_clk_on | input | 1 | Clock-enable bit of the enable pair |
| tx_push | input | 1 | Store one stereo pair |
| tx_left | input | SAMPLE_W | Left transmit sample |
| tx_right | input | SAMPLE_W | Right transmit sample |
| tx_full | output | 1 | Transmit holding slot occupied |
| rx_pop | input | 1 | Free the received pair |
| rx_left | output | SAMPLE_W | Left received sample |
| rx_right | output | SAMPLE_W | Right received sample |
| rx_avail | output | 1 | Received pair waiting |
| flow_clr | input | 4 | Per-bit clear of the sticky flags |
| flow_err | output | 4 | Sticky flow-error flags |
| bclk | output | 1 | Bit clock pin |
| ws | output | 1 | Word-select pin |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |

## Verification
The bench uses the default parameters: 24-bit sample ports, 4 master clocks per bit and 32 slots per channel. These give the full 256-clock frame. Every legal width fits inside a half-frame, so the LSB-aligned offsets from 8 up to 24 slots can all be reached. A pin-level decoder in the bench rebuilds each transmitted frame and drives a receive frame with ones in the unused slots, so bit placement and masking are checked from outside. Widths and framings are paired with both inversion bits, and directed runs then cover the enable pair, illegal settings, the internal loop and every sticky flag.

// File: rtl/i2s_eng_pkg.sv
// Package: shared framing types and slot-placement arithmetic.
// Assumes widths are counted in bits and slot positions run 0..slots-1 per half.
package i2s_eng_pkg;

    typedef enum logic [1:0] {
        FMT_STD   = 2'd0,
        FMT_MSB   = 2'd1,
        FMT_LSB   = 2'd2,
        FMT_RSVD  = 2'd3
    } frame_fmt_e;

    localparam int FLAG_TX_UNDER = 0;
    localparam int FLAG_TX_OVER  = 1;
    localparam int FLAG_RX_UNDER = 2;
    localparam int FLAG_RX_OVER  = 3;
    localparam int FLAG_N        = 4;

    // True when the width code is one of the supported sample sizes.
    function automatic logic width_ok(logic [4:0] w, int max_w, int slots);
        logic legal;
        legal = (w == 5'd8) || (w == 5'd16) || (w == 5'd18) ||
                (w == 5'd20) || (w == 5'd24);
        return legal && (int'(w) <= max_w) && (int'(w) <= slots);
    endfunction

    // Slot in which the MSB lands for a given framing.
    function automatic int first_slot(frame_fmt_e f, int w, int slots);
        case (f)
            FMT_STD: return 1;
            FMT_LSB: return slots - w;
            default: return 0;
        endcase
    endfunction

    // True when slot position pos carries a sample bit.
    function automatic logic slot_used(frame_fmt_e f, int w, int pos, int slots);
        int rel;
        rel = pos - first_slot(f, w, slots);
        return (rel >= 0) && (rel < w);
    endfunction

    // Sample bit index carried by slot position pos.
    function automatic int slot_bit(frame_fmt_e f, int w, int pos, int slots);
        return w - 1 - (pos - first_slot(f, w, slots));
    endfunction

endpackage

// File: rtl/i2s_clk_gen.sv
// Clock generator: divides the master clock into bit clock and word-select.
// Assumes a single free-running counter; held at all-ones (idle levels) when not running.
module i2s_clk_gen #(
    parameter int BIT_DIV_LOG2 = 2,
    parameter int SLOT_LOG2    = 5
) (
    input  logic                 mclk,
    input  logic                 rst_n,
    input  logic                 run,
    output logic                 bclk_raw,
    output logic                 ws_raw,
    output logic [SLOT_LOG2-1:0] pos,
    output logic                 chan,
    output logic                 frame_edge,
    output logic                 sample_stb,
    output logic                 frame_seen
);
    localparam int CW = BIT_DIV_LOG2 + SLOT_LOG2 + 1;
    localparam logic [BIT_DIV_LOG2-1:0] PH_SAMPLE = 1 << (BIT_DIV_LOG2 - 1);

    logic [CW-1:0] cnt;

    // Frame position counter; rests at the last slot while idle.
    always_ff @(posedge mclk) begin
        if (!rst_n)   cnt <= '1;
        else if (!run) cnt <= '1;
        else          cnt <= cnt + 1'b1;
    end

    // Marks that at least one frame has started since running began.
    always_ff @(posedge mclk) begin
        if (!rst_n)          frame_seen <= 1'b0;
        else if (!run)       frame_seen <= 1'b0;
        else if (frame_edge) frame_seen <= 1'b1;
    end

    assign bclk_raw   = cnt[BIT_DIV_LOG2-1];
    assign ws_raw     = cnt[CW-1];
    assign chan       = cnt[CW-1];
    assign pos        = cnt[CW-2:BIT_DIV_LOG2];
    assign frame_edge = run && (&cnt);
    assign sample_stb = run && (cnt[BIT_DIV_LOG2-1:0] == PH_SAMPLE);

    // R1: word-select only moves while the bit clock is low
    a_r1_ws_on_low: assert property (@(posedge mclk) disable iff (!rst_n)
        (!$stable(ws_raw) && run) |-> !bclk_raw);

endmodule

// File: rtl/i2s_tx_path.sv
// Transmit path: one-pair holding slot, per-frame active pair, slot serializer.
// Assumes configuration is static while running; serial bit is combinational from flops.
module i2s_tx_path
    import i2s_eng_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_LOG2 = 5
) (
    input  logic                 mclk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 tx_en,
    input  frame_fmt_e           fmt,
    input  logic [4:0]           width,
    input  logic                 push,
    input  logic [SAMPLE_W-1:0]  push_l,
    input  logic [SAMPLE_W-1:0]  push_r,
    input  logic                 frame_edge,
    input  logic [SLOT_LOG2-1:0] pos,
    input  logic                 chan,
    output logic                 full,
    output logic                 sd,
    output logic                 under_ev,
    output logic                 over_ev
);
    localparam int SLOTS = 1 << SLOT_LOG2;
    localparam int IW    = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] pend_l, pend_r, act_l, act_r, word;
    logic [IW-1:0]       idx;
    logic                used;

    // Holding slot: consumed at frame start, filled by a push when empty.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            full   <= 1'b0;
            pend_l <= '0;
            pend_r <= '0;
        end else begin
            if (frame_edge && tx_en) full <= 1'b0;
            if (push && !full) begin
                full   <= 1'b1;
                pend_l <= push_l;
                pend_r <= push_r;
            end
        end
    end

    // Active pair for the frame now starting; zeros when idle or starved.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            act_l <= '0;
            act_r <= '0;
        end else if (frame_edge) begin
            act_l <= (tx_en && full) ? pend_l : '0;
            act_r <= (tx_en && full) ? pend_r : '0;
        end
    end

    // Serial bit for the current slot.
    always_comb begin
        used = slot_used(fmt, int'(width), int'(pos), SLOTS);
        idx  = IW'(slot_bit(fmt, int'(width), int'(pos), SLOTS));
        word = chan ? act_r : act_l;
        sd   = run && used && word[idx];
    end

    assign under_ev = frame_edge && tx_en && !full;
    assign over_ev  = push && full;

    // R6: a stored pair stays put until a frame consumes it
    a_r6_hold_pending: assert property (@(posedge mclk) disable iff (!rst_n)
        (full && !(frame_edge && tx_en)) |=> (full && $stable(pend_l) && $stable(pend_r)));

endmodule

// File: rtl/i2s_rx_path.sv
// Receive path: slot deserializer and one-pair output holder.
// Assumes sampling strobe at the bit-clock rising phase; unused slots never write.
module i2s_rx_path
    import i2s_eng_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_LOG2 = 5
) (
    input  logic                 mclk,
    input  logic                 rst_n,
    input  logic                 rx_en,
    input  frame_fmt_e           fmt,
    input  logic [4:0]           width,
    input  logic                 sd_line,
    input  logic                 sample_stb,
    input  logic                 frame_edge,
    input  logic                 frame_seen,
    input  logic [SLOT_LOG2-1:0] pos,
    input  logic                 chan,
    input  logic                 pop,
    output logic                 avail,
    output logic [SAMPLE_W-1:0]  out_l,
    output logic [SAMPLE_W-1:0]  out_r,
    output logic                 under_ev,
    output logic                 over_ev
);
    localparam int SLOTS = 1 << SLOT_LOG2;
    localparam int IW    = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] acc_l, acc_r;
    logic [IW-1:0]       idx;
    logic                used, deliver;

    always_comb begin
        used = slot_used(fmt, int'(width), int'(pos), SLOTS);
        idx  = IW'(slot_bit(fmt, int'(width), int'(pos), SLOTS));
    end

    assign deliver = frame_edge && frame_seen && rx_en;

    // Accumulator: cleared at each frame start, filled bit by bit.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            acc_l <= '0;
            acc_r <= '0;
        end else if (frame_edge) begin
            acc_l <= '0;
            acc_r <= '0;
        end else if (sample_stb && used) begin
            if (chan) acc_r[idx] <= sd_line;
            else      acc_l[idx] <= sd_line;
        end
    end

    // Output holder: takes a finished frame when free, released by pop.
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            avail <= 1'b0;
            out_l <= '0;
            out_r <= '0;
        end else if (deliver && (!avail || pop)) begin
            avail <= 1'b1;
            out_l <= acc_l;
            out_r <= acc_r;
        end else if (pop) begin
            avail <= 1'b0;
        end
    end

    assign under_ev = pop && !avail;
    assign over_ev  = deliver && avail && !pop;

    // R7: an unread pair is held unchanged
    a_r7_hold_output: assert property (@(posedge mclk) disable iff (!rst_n)
        (avail && !pop) |=> (avail && $stable(out_l) && $stable(out_r)));

endmodule

// File: rtl/i2s_flow_flags.sv
// Sticky flag bank: events set bits, a mask clears them, setting wins.
// Assumes one-cycle event pulses.
module i2s_flow_flags #(
    parameter int N = 4
) (
    input  logic         mclk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    // Flag update: clear by mask, then OR in new events.
    always_ff @(posedge mclk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_ev;
    end

    // R8: uncleared flags never drop
    a_r8_sticky: assert property (@(posedge mclk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

endmodule

// File: rtl/i2s_master_engine.sv
// Top: stereo serial master with three framings, five widths, polarity control,
// loopback and sticky flow flags. Assumes mclk = 256 x sample rate at defaults
// and configuration held steady while running.
module i2s_master_engine
    import i2s_eng_pkg::*;
#(
    parameter int SAMPLE_W     = 24,
    parameter int BIT_DIV_LOG2 = 2,
    parameter int SLOT_LOG2    = 5
) (
    input  logic                mclk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_fmt,
    input  logic [4:0]          cfg_width,
    input  logic                cfg_bclk_inv,
    input  logic                cfg_ws_inv,
    input  logic                cfg_loop,
    input  logic                cfg_tx_en,
    input  logic                cfg_rx_en,
    input  logic                ctl_off,
    input  logic                ctl_clk_on,
    input  logic                tx_push,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_full,
    input  logic                rx_pop,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_avail,
    input  logic [3:0]          flow_clr,
    output logic [3:0]          flow_err,
    output logic                bclk,
    output logic                ws,
    output logic                sd_out,
    input  logic                sd_in
);
    localparam int SLOTS = 1 << SLOT_LOG2;

    frame_fmt_e             fmt;
    logic                   run, bclk_raw, ws_raw, chan;
    logic                   frame_edge, sample_stb, frame_seen;
    logic [SLOT_LOG2-1:0]   pos;
    logic                   sd_tx, sd_line;
    logic                   tx_under, tx_over, rx_under, rx_over;
    logic [FLAG_N-1:0]      events;

    assign fmt = frame_fmt_e'(cfg_fmt);
    assign run = ctl_clk_on && !ctl_off && (fmt != FMT_RSVD) &&
                 width_ok(cfg_width, SAMPLE_W, SLOTS);

    i2s_clk_gen #(.BIT_DIV_LOG2(BIT_DIV_LOG2), .SLOT_LOG2(SLOT_LOG2)) u_clk (
        .mclk(mclk), .rst_n(rst_n), .run(run),
        .bclk_raw(bclk_raw), .ws_raw(ws_raw), .pos(pos), .chan(chan),
        .frame_edge(frame_edge), .sample_stb(sample_stb), .frame_seen(frame_seen)
    );

    i2s_tx_path #(.SAMPLE_W(SAMPLE_W), .SLOT_LOG2(SLOT_LOG2)) u_tx (
        .mclk(mclk), .rst_n(rst_n), .run(run), .tx_en(cfg_tx_en),
        .fmt(fmt), .width(cfg_width),
        .push(tx_push), .push_l(tx_left), .push_r(tx_right),
        .frame_edge(frame_edge), .pos(pos), .chan(chan),
        .full(tx_full), .sd(sd_tx), .under_ev(tx_under), .over_ev(tx_over)
    );

    assign sd_line = cfg_loop ? sd_tx : sd_in;

    i2s_rx_path #(.SAMPLE_W(SAMPLE_W), .SLOT_LOG2(SLOT_LOG2)) u_rx (
        .mclk(mclk), .rst_n(rst_n), .rx_en(cfg_rx_en),
        .fmt(fmt), .width(cfg_width), .sd_line(sd_line),
        .sample_stb(sample_stb), .frame_edge(frame_edge), .frame_seen(frame_seen),
        .pos(pos), .chan(chan), .pop(rx_pop),
        .avail(rx_avail), .out_l(rx_left), .out_r(rx_right),
        .under_ev(rx_under), .over_ev(rx_over)
    );

    always_comb begin
        events                = '0;
        events[FLAG_TX_UNDER] = tx_under;
        events[FLAG_TX_OVER]  = tx_over;
        events[FLAG_RX_UNDER] = rx_under;
        events[FLAG_RX_OVER]  = rx_over;
    end

    i2s_flow_flags #(.N(FLAG_N)) u_flags (
        .mclk(mclk), .rst_n(rst_n), .set_ev(events), .clr(flow_clr), .flags(flow_err)
    );

    assign bclk   = bclk_raw ^ cfg_bclk_inv;
    assign ws     = ws_raw ^ cfg_ws_inv;
    assign sd_out = sd_tx;

    // R9: idle engine rests at fixed pin levels with a silent data line
    a_r9_idle_quiet: assert property (@(posedge mclk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (bclk_raw && ws_raw && !sd_out));

    // R10: transmit data holds while the bit clock is high
    a_r10_sd_stable_high: assert property (@(posedge mclk) disable iff (!rst_n)
        (run && $past(run) && bclk_raw && $past(bclk_raw)) |-> $stable(sd_out));

endmodule

// File: tb/tb_i2s_master_engine.sv
// Bench: vector table walked by one loop, then directed tests. A pin-level
// monitor rebuilds transmitted frames and drives receive frames.
module tb_i2s_master_engine;

    logic        mclk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [4:0]  cfg_width = 5'd16;
    logic        cfg_bclk_inv = 1'b0, cfg_ws_inv = 1'b0, cfg_loop = 1'b0;
    logic        cfg_tx_en = 1'b0, cfg_rx_en = 1'b0;
    logic        ctl_off = 1'b1, ctl_clk_on = 1'b0;
    logic        tx_push = 1'b0, rx_pop = 1'b0;
    logic [23:0] tx_left = '0, tx_right = '0;
    logic [3:0]  flow_clr = '0;
    logic        tx_full, rx_avail, bclk, ws, sd_out;
    logic [23:0] rx_left, rx_right;
    logic [3:0]  flow_err;
    logic        sd_in = 1'b0;

    int tests = 0, fails = 0;

    always #2 mclk = ~mclk;

    i2s_master_engine dut (
        .mclk(mclk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_width(cfg_width),
        .cfg_bclk_inv(cfg_bclk_inv), .cfg_ws_inv(cfg_ws_inv), .cfg_loop(cfg_loop),
        .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en), .ctl_off(ctl_off),
        .ctl_clk_on(ctl_clk_on), .tx_push(tx_push), .tx_left(tx_left),
        .tx_right(tx_right), .tx_full(tx_full), .rx_pop(rx_pop), .rx_left(rx_left),
        .rx_right(rx_right), .rx_avail(rx_avail), .flow_clr(flow_clr),
        .flow_err(flow_err), .bclk(bclk), .ws(ws), .sd_out(sd_out), .sd_in(sd_in)
    );

    typedef struct packed {
        logic [1:0]  f;
        logic [4:0]  w;
        logic        bi;
        logic        wi;
        logic [23:0] l;
        logic [23:0] r;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 5'd16, 1'b0, 1'b0, 24'h00A5C3, 24'h00F00F},
        '{2'd1, 5'd24, 1'b0, 1'b0, 24'h9ABCDE, 24'h123457},
        '{2'd2, 5'd18, 1'b0, 1'b0, 24'h02B3C5, 24'h01F00E},
        '{2'd0, 5'd20, 1'b1, 1'b1, 24'h0F1E2D, 24'h0A5A5B},
        '{2'd2, 5'd8,  1'b0, 1'b1, 24'h0000C9, 24'h00003A},
        '{2'd1, 5'd8,  1'b1, 1'b0, 24'h000081, 24'h00007E},
        '{2'd2, 5'd24, 1'b1, 1'b0, 24'hC0FFEE, 24'h5EED01}
    };

    // Monitor state
    logic        bn_q = 1'b1, wn_q = 1'b1, drive_en = 1'b0, sd_const = 1'b0, sd_seen = 1'b0;
    logic [63:0] cap = '0, rxfr = '0;
    int          slot = 0, flen = 0, rises = 0, per = 0, last_rise = -1, cyc = 0;

    // Pin decoder: tracks slots, captures sd_out, drives sd_in.
    always @(negedge mclk) begin
        logic bn, wn;
        cyc++;
        bn = bclk ^ cfg_bclk_inv;
        wn = ws ^ cfg_ws_inv;
        if (bn_q && !bn) begin
            if (wn_q && !wn) begin flen = slot + 1; slot = 0; end
            else slot = (slot + 1) & 63;
            sd_in = drive_en ? rxfr[slot] : sd_const;
        end
        if (!bn_q && bn) begin
            cap[slot] = sd_out;
            rises++;
            if (last_rise >= 0) per = cyc - last_rise;
            last_rise = cyc;
        end
        if (sd_out) sd_seen = 1'b1;
        bn_q = bn;
        wn_q = wn;
    end

    // Expected frame built from the placement rules (R2).
    function automatic logic [63:0] frame_bits(int f, int w, logic [23:0] l, logic [23:0] r, logic fill);
        logic [63:0] res;
        for (int s = 0; s < 64; s++) begin
            int p;
            logic [23:0] d;
            logic b, use_it;
            p = s % 32;
            d = (s >= 32) ? r : l;
            use_it = 1'b0;
            b = 1'b0;
            if (f == 0 && p >= 1 && p <= w)      begin use_it = 1'b1; b = d[w - p]; end
            else if (f == 1 && p < w)            begin use_it = 1'b1; b = d[w - 1 - p]; end
            else if (f == 2 && p >= 32 - w)      begin use_it = 1'b1; b = d[31 - p]; end
            res[s] = use_it ? b : fill;
        end
        return res;
    endfunction

    function automatic logic [23:0] wmask(int w);
        logic [31:0] m;
        m = (32'd1 << w) - 32'd1;
        return m[23:0];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge mclk);
    endtask

    task automatic push_pair(logic [23:0] l, logic [23:0] r);
        tx_left = l; tx_right = r; tx_push = 1'b1;
        cycles(1);
        tx_push = 1'b0;
    endtask

    task automatic pop_pair();
        rx_pop = 1'b1;
        cycles(1);
        rx_pop = 1'b0;
    endtask

    task automatic clear_flags();
        flow_clr = 4'hF;
        cycles(1);
        flow_clr = 4'h0;
    endtask

    task automatic wait_avail();
        int n = 0;
        while (!rx_avail && n < 800) begin cycles(1); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge mclk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        // R11: reset state
        chk("R11 reset flags/handshakes", {tx_full, rx_avail, flow_err}, 6'b0);
        chk("R11 reset pins", {bclk, ws, sd_out}, 3'b110);

        // Table walk: framings, widths, polarities (R2 R3 R4 R6 R7 R8)
        for (int i = 0; i < NV; i++) begin
            logic [23:0] rl, rr;
            logic [63:0] got;
            cfg_fmt = VEC[i].f; cfg_width = VEC[i].w;
            cfg_bclk_inv = VEC[i].bi; cfg_ws_inv = VEC[i].wi;
            cfg_loop = 1'b0; cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
            ctl_clk_on = 1'b1; ctl_off = 1'b1;
            cycles(3);
            clear_flags();
            push_pair(VEC[i].l, VEC[i].r);
            rl = VEC[i].r ^ 24'h3C5A69;
            rr = VEC[i].l ^ 24'h96C3A5;
            rxfr = frame_bits(int'(VEC[i].f), int'(VEC[i].w), rl, rr, 1'b1);
            drive_en = 1'b1;
            ctl_off = 1'b0;
            wait_avail();
            got = cap;
            chk($sformatf("R2 R3 R4 tx frame vec%0d", i), got,
                frame_bits(int'(VEC[i].f), int'(VEC[i].w), VEC[i].l, VEC[i].r, 1'b0));
            chk($sformatf("R7 rx left vec%0d", i), rx_left, rl & wmask(int'(VEC[i].w)));
            chk($sformatf("R7 rx right vec%0d", i), rx_right, rr & wmask(int'(VEC[i].w)));
            cycles(1);
            chk($sformatf("R8 R6 underflow only vec%0d", i), flow_err, 4'b0001);
            pop_pair();
            ctl_off = 1'b1;
            drive_en = 1'b0;
            cycles(3);
        end

        // R9: two-step start; both bits set keeps the engine idle
        cfg_bclk_inv = 1'b0; cfg_ws_inv = 1'b0; cfg_fmt = 2'd0; cfg_width = 5'd16;
        cfg_tx_en = 1'b0; cfg_rx_en = 1'b0; cfg_loop = 1'b0;
        ctl_clk_on = 1'b1; ctl_off = 1'b1;
        cycles(3);
        clear_flags();
        rises = 0;
        cycles(40);
        chk("R9 clock held with disable set", rises, 0);
        sd_seen = 1'b0;
        ctl_off = 1'b0;
        cycles(600);
        chk("R1 bit period 4 mclk", per, 4);
        chk("R1 frame of 64 bit slots", flen, 64);
        chk("R6 tx disabled sends zeros", sd_seen, 1'b0);
        chk("R6 R7 no flags with both paths off", flow_err, 4'b0);
        chk("R7 rx disabled delivers nothing", rx_avail, 1'b0);
        ctl_clk_on = 1'b0; ctl_off = 1'b1;
        cycles(2);
        rises = 0;
        cycles(40);
        chk("R9 disable stops clock", rises, 0);
        chk("R9 idle pins", {bclk, ws, sd_out}, 3'b110);

        // R3: illegal width and reserved framing stay idle
        cfg_width = 5'd12; ctl_clk_on = 1'b1; ctl_off = 1'b0;
        cycles(2); rises = 0; cycles(60);
        chk("R3 width 12 idle", rises, 0);
        cfg_width = 5'd16; cfg_fmt = 2'd3;
        cycles(2); rises = 0; cycles(60);
        chk("R3 framing 3 idle", rises, 0);
        ctl_off = 1'b1; cfg_fmt = 2'd1; cfg_width = 5'd24;

        // R5: loopback ignores sd_in
        cfg_loop = 1'b1; cfg_tx_en = 1'b1; cfg_rx_en = 1'b1;
        drive_en = 1'b0; sd_const = 1'b1; sd_in = 1'b1;
        cycles(3);
        clear_flags();
        push_pair(24'hA1B2C3, 24'h4D5E6F);
        ctl_off = 1'b0;
        wait_avail();
        chk("R5 loop left", rx_left, 24'hA1B2C3);
        chk("R5 loop right", rx_right, 24'h4D5E6F);
        // R8: second frame arrives unread -> receive overflow, old pair kept
        cycles(280);
        chk("R8 rx overflow flag", flow_err[3], 1'b1);
        chk("R8 old pair kept", rx_left, 24'hA1B2C3);
        ctl_off = 1'b1;
        cycles(2);
        pop_pair();
        clear_flags();
        chk("R8 clear mask", flow_err, 4'b0);
        pop_pair();
        cycles(1);
        chk("R8 rx underflow flag", flow_err, 4'b0100);
        push_pair(24'h1, 24'h2);
        push_pair(24'h3, 24'h4);
        cycles(1);
        chk("R8 R6 tx overflow flag", flow_err, 4'b0110);
        chk("R6 tx full after push", tx_full, 1'b1);
        cycles(2);
        chk("R8 flags sticky", flow_err, 4'b0110);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule